// File: doc/BRIEF.md
# S/T Line Activation Controller

This block sequences the layer-1 handshake of a four-wire ISDN subscriber line. It brings the link up from the deactivated state and takes it down again, at either end of the line. A static mode pin selects the network-side role or the terminal-side role. The host gives two control bits: one starts activation and one forces deactivation. The framer reports whether it holds frame alignment. A receive decoder reports which INFO signal is arriving, as a 3-bit code.

From these inputs the controller picks the INFO signal to transmit and the value of the A-bit. It also reports a status flag that reads 1 only while the link is fully up and the host still asks for activation. The network side sends INFO2 with the A-bit at 0 until the terminal answers with valid framed data, and only then sends INFO4 with the A-bit at 1.

A loss timer counts consecutive bad received frames once the link has reached sync. When the count reaches the limit, the controller drops back to the deactivated state. A force-sync control bit holds the link up regardless of the timer.

Top module: `sti_link_actv`

## Requirements
- R1: While reset is asserted and in the cycle it releases, tx_info is 0 (INFO0), a_bit is 0 and sync_act is 0.
- R2: In the deactivated state (tx_info = 0) with act_req at 0, the controller stays deactivated whatever rx_info and fsync_ok carry.
- R3: Network side (mode_nt = 1): act_req = 1 in the deactivated state makes tx_info 2 (INFO2) with a_bit 0 one clock later.
- R4: Network side: while sending INFO2, receiving rx_info = 3 (INFO3) with fsync_ok = 1 moves to tx_info 4 (INFO4) with a_bit 1 one clock later. Without fsync_ok the controller stays at INFO2.
- R5: Terminal side (mode_nt = 0): act_req sends INFO1 (code 1). Receiving rx_info = 2 with fsync_ok then sends INFO3 (code 3). Receiving rx_info = 4 with fsync_ok brings the link up, still sending INFO3.
- R6: deact_req = 1 returns the controller to INFO0 on the next clock from any state and wins over act_req. It stays there while deact_req is held.
- R7: sync_act is 1 exactly when the link is up, act_req is 1 and deact_req is 0. It follows act_req and deact_req in the same cycle.
- R8: Dropping act_req while the link is up keeps the link state (tx_info and a_bit unchanged) but clears sync_act.
- R9: In the sync or up state, a frame_tick is bad when fsync_ok is 0 or rx_info is 0. LOSS_FRAMES consecutive bad ticks (default 4) return the controller to INFO0 one clock after the last of them. A good tick restarts the count.
- R10: With force_sync = 1, bad frames never drop the link.
- R11: a_bit is 1 only on the network side with the link up. It is 0 in every terminal-side state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_nt | input | 1 | 1 = network side, 0 = terminal side |
| act_req | input | 1 | Host activation request |
| deact_req | input | 1 | Host deactivation request (priority) |
| force_sync | input | 1 | Hold sync despite lost frames |
| fsync_ok | input | 1 | Framer holds frame alignment |
| frame_tick | input | 1 | One-cycle pulse per received frame |
| rx_info | input | 3 | Decoded received INFO code (0..4) |
| tx_info | output | 3 | INFO code to transmit (0..4) |
| a_bit | output | 1 | Transmitted A-bit value |
| sync_act | output | 1 | Sync/activated status |

## Verification
The assertions assume that mode_nt changes only while the controller sends INFO0, and that rx_info carries only codes 0 to 4. The bench changes the mode only after a deactivation has taken effect, and drives only legal codes. The transition assertions also take it that rx_info and fsync_ok are sampled at the clock edge they are meant for. The bench therefore changes inputs only on falling edges, and pulses frame_tick for exactly one cycle per frame.

// File: rtl/sti_actv_pkg.sv
package sti_actv_pkg;
   localparam int INFO_W = 3;

   typedef enum logic [INFO_W-1:0] {
      INFO0 = 3'd0,
      INFO1 = 3'd1,
      INFO2 = 3'd2,
      INFO3 = 3'd3,
      INFO4 = 3'd4
   } info_e;

   typedef enum logic [1:0] {
      LS_IDLE,
      LS_REQ,
      LS_SYNC,
      LS_UP
   } link_st_e;
endpackage

// File: rtl/sti_loss_timer.sv
module sti_loss_timer #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   input  logic bad,
   output logic expired
);
   localparam int unsigned CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] TOP = CW'(LIMIT);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (tick) begin
         if (!bad) begin
            cnt <= '0;
         end else if (cnt != TOP) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign expired = (cnt == TOP);
endmodule

// File: rtl/sti_actv_fsm.sv
module sti_actv_fsm
   import sti_actv_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mode_nt,
   input  logic                act_req,
   input  logic                deact_req,
   input  logic                fsync_ok,
   input  logic [INFO_W-1:0]   rx_info,
   input  logic                loss_drop,
   output link_st_e            st
);
   link_st_e nxt;

   always_comb begin
      nxt = st;
      if (deact_req) begin
         nxt = LS_IDLE;
      end else begin
         unique case (st)
            LS_IDLE: if (act_req) nxt = LS_REQ;
            LS_REQ: begin
               if (fsync_ok) begin
                  if (mode_nt) begin
                     if (rx_info == INFO3) nxt = LS_UP;
                  end else if (rx_info == INFO2) begin
                     nxt = LS_SYNC;
                  end else if (rx_info == INFO4) begin
                     nxt = LS_UP;
                  end
               end
            end
            LS_SYNC: begin
               if (loss_drop) nxt = LS_IDLE;
               else if (fsync_ok && rx_info == INFO4) nxt = LS_UP;
            end
            LS_UP: if (loss_drop) nxt = LS_IDLE;
            default: nxt = LS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= LS_IDLE;
      else        st <= nxt;
   end
endmodule

// File: rtl/sti_tx_map.sv
module sti_tx_map
   import sti_actv_pkg::*;
(
   input  link_st_e            st,
   input  logic                mode_nt,
   output logic [INFO_W-1:0]   tx_info,
   output logic                a_bit
);
   always_comb begin
      a_bit = 1'b0;
      unique case (st)
         LS_IDLE: tx_info = INFO0;
         LS_REQ:  tx_info = mode_nt ? INFO2 : INFO1;
         LS_SYNC: tx_info = INFO3;
         LS_UP: begin
            tx_info = mode_nt ? INFO4 : INFO3;
            a_bit   = mode_nt;
         end
         default: tx_info = INFO0;
      endcase
   end
endmodule

// File: rtl/sti_link_actv.sv
module sti_link_actv
   import sti_actv_pkg::*;
#(
   parameter int unsigned LOSS_FRAMES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_nt,
   input  logic       act_req,
   input  logic       deact_req,
   input  logic       force_sync,
   input  logic       fsync_ok,
   input  logic       frame_tick,
   input  logic [2:0] rx_info,
   output logic [2:0] tx_info,
   output logic       a_bit,
   output logic       sync_act
);
   if (LOSS_FRAMES > 1023) begin : g_bad_limit
      $error("LOSS_FRAMES must not exceed 1023");
   end

   link_st_e st;
   logic     in_sync;
   logic     bad_frame;
   logic     loss_exp;
   logic     loss_drop;

   assign in_sync   = (st == LS_SYNC) || (st == LS_UP);
   assign bad_frame = !fsync_ok || (rx_info == INFO0);
   assign loss_drop = loss_exp && !force_sync;

   if (LOSS_FRAMES == 0) begin : g_no_timer
      assign loss_exp = 1'b0;
   end else begin : g_timer
      sti_loss_timer #(.LIMIT(LOSS_FRAMES)) u_timer (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (!in_sync),
         .tick    (frame_tick),
         .bad     (bad_frame),
         .expired (loss_exp)
      );
   end

   sti_actv_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_nt   (mode_nt),
      .act_req   (act_req),
      .deact_req (deact_req),
      .fsync_ok  (fsync_ok),
      .rx_info   (rx_info),
      .loss_drop (loss_drop),
      .st        (st)
   );

   sti_tx_map u_map (
      .st      (st),
      .mode_nt (mode_nt),
      .tx_info (tx_info),
      .a_bit   (a_bit)
   );

   assign sync_act = (st == LS_UP) && act_req && !deact_req;
endmodule

// File: rtl/sti_link_actv_chk.sv
module sti_link_actv_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mode_nt,
   input logic       act_req,
   input logic       deact_req,
   input logic       force_sync,
   input logic       fsync_ok,
   input logic [2:0] rx_info,
   input logic [2:0] tx_info,
   input logic       a_bit,
   input logic       sync_act
);
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_info == 3'd0 && !act_req) |=> tx_info == 3'd0);

   assert_info4_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(a_bit) |-> ($past(rx_info) == 3'd3 && $past(fsync_ok)));

   assert_deact_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      deact_req |=> tx_info == 3'd0);

   assert_status_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sync_act |-> (mode_nt ? tx_info == 3'd4 : tx_info == 3'd3));

   assert_force_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_nt && tx_info == 3'd4 && force_sync && !deact_req) |=> tx_info == 3'd4);

   assert_abit_side_R11: assert property (@(posedge clk) disable iff (!rst_n)
      a_bit |-> mode_nt);
endmodule

bind sti_link_actv sti_link_actv_chk u_chk (.*);

// File: tb/sti_link_actv_bench.sv
module sti_link_actv_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_nt = 1'b0;
   logic       act_req = 1'b0;
   logic       deact_req = 1'b0;
   logic       force_sync = 1'b0;
   logic       fsync_ok = 1'b0;
   logic       frame_tick = 1'b0;
   logic [2:0] rx_info = 3'd0;
   logic [2:0] tx_info;
   logic       a_bit;
   logic       sync_act;

   always #10 clk = ~clk;

   sti_link_actv u_sti_link_actv (
      .clk(clk), .rst_n(rst_n), .mode_nt(mode_nt), .act_req(act_req),
      .deact_req(deact_req), .force_sync(force_sync), .fsync_ok(fsync_ok),
      .frame_tick(frame_tick), .rx_info(rx_info), .tx_info(tx_info),
      .a_bit(a_bit), .sync_act(sync_act)
   );

   typedef struct {
      int         when;
      string      tag;
      logic [2:0] tx;
      logic       a;
      logic       s;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   // monitor: samples 5 ns after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         #5;
         for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].when == cyc) begin
               checks++;
               if (tx_info !== q[i].tx || a_bit !== q[i].a || sync_act !== q[i].s) begin
                  errors++;
                  $display("FAIL %s cycle %0d: tx=%0d a=%0b s=%0b expected tx=%0d a=%0b s=%0b",
                           q[i].tag, cyc, tx_info, a_bit, sync_act, q[i].tx, q[i].a, q[i].s);
               end
               q.delete(i);
            end
         end
      end
   end

   task automatic expect_at(input string tag, input int d, input logic [2:0] tx,
                            input logic a, input logic s);
      exp_t e;
      e.when = cyc + d; e.tag = tag; e.tx = tx; e.a = a; e.s = s;
      q.push_back(e);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame();
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
   endtask

   task automatic report();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not end, expected completion");
         report();
      end
   end

   initial begin
      @(negedge clk);
      expect_at("R1 in reset", 1, 3'd0, 1'b0, 1'b0);
      idle(2);
      rst_n = 1'b1;
      expect_at("R1 after release", 1, 3'd0, 1'b0, 1'b0);
      idle(1);

      // R2: no activation without request
      mode_nt = 1'b1; rx_info = 3'd3; fsync_ok = 1'b1; act_req = 1'b0;
      expect_at("R2 idle hold", 2, 3'd0, 1'b0, 1'b0);
      expect_at("R2 idle hold late", 4, 3'd0, 1'b0, 1'b0);
      idle(4);

      // R3: NT sends INFO2
      rx_info = 3'd0; fsync_ok = 1'b0; act_req = 1'b1;
      expect_at("R3 info2", 1, 3'd2, 1'b0, 1'b0);
      idle(1);
      frame(); frame();
      expect_at("R3 info2 no loss", 1, 3'd2, 1'b0, 1'b0);
      idle(1);

      // R4: needs INFO3 and frame sync
      rx_info = 3'd3; fsync_ok = 1'b0;
      expect_at("R4 no sync", 2, 3'd2, 1'b0, 1'b0);
      idle(2);
      fsync_ok = 1'b1;
      expect_at("R4 R7 info4", 1, 3'd4, 1'b1, 1'b1);
      idle(1);

      // R8: drop request keeps link
      act_req = 1'b0;
      expect_at("R8 hold", 1, 3'd4, 1'b1, 1'b0);
      expect_at("R8 hold late", 3, 3'd4, 1'b1, 1'b0);
      idle(3);
      act_req = 1'b1;
      expect_at("R7 status back", 1, 3'd4, 1'b1, 1'b1);
      idle(1);

      // R9: loss counting
      rx_info = 3'd0; fsync_ok = 1'b0;
      frame(); frame(); frame();
      expect_at("R9 three bad", 2, 3'd4, 1'b1, 1'b1);
      idle(2);
      rx_info = 3'd3; fsync_ok = 1'b1;
      frame();
      rx_info = 3'd0; fsync_ok = 1'b0;
      frame(); frame(); frame();
      expect_at("R9 restart count", 1, 3'd4, 1'b1, 1'b1);
      frame();
      expect_at("R9 drop", 1, 3'd0, 1'b0, 1'b0);
      expect_at("R3 re-request", 2, 3'd2, 1'b0, 1'b0);
      idle(2);

      // R10: force sync
      rx_info = 3'd3; fsync_ok = 1'b1;
      expect_at("R4 reup", 1, 3'd4, 1'b1, 1'b1);
      idle(1);
      force_sync = 1'b1; rx_info = 3'd0; fsync_ok = 1'b0;
      repeat (6) frame();
      expect_at("R10 held", 1, 3'd4, 1'b1, 1'b1);
      expect_at("R10 held late", 3, 3'd4, 1'b1, 1'b1);
      idle(3);
      rx_info = 3'd3; fsync_ok = 1'b1;
      frame();
      force_sync = 1'b0;

      // R6: deactivation wins
      deact_req = 1'b1;
      expect_at("R6 deact", 1, 3'd0, 1'b0, 1'b0);
      expect_at("R6 deact held", 3, 3'd0, 1'b0, 1'b0);
      idle(3);
      deact_req = 1'b0;
      expect_at("R6 release", 1, 3'd2, 1'b0, 1'b0);
      idle(1);

      // TE side
      deact_req = 1'b1; act_req = 1'b0; rx_info = 3'd0; fsync_ok = 1'b0;
      idle(1);
      mode_nt = 1'b0; deact_req = 1'b0;
      expect_at("R2 te idle", 2, 3'd0, 1'b0, 1'b0);
      idle(2);
      act_req = 1'b1;
      expect_at("R5 info1", 1, 3'd1, 1'b0, 1'b0);
      idle(1);
      rx_info = 3'd2; fsync_ok = 1'b1;
      expect_at("R5 info3 sync", 1, 3'd3, 1'b0, 1'b0);
      idle(1);
      rx_info = 3'd4;
      expect_at("R5 R11 te up", 1, 3'd3, 1'b0, 1'b1);
      idle(1);
      rx_info = 3'd0; fsync_ok = 1'b0;
      repeat (4) frame();
      expect_at("R9 te drop", 1, 3'd0, 1'b0, 1'b0);
      idle(1);
      deact_req = 1'b1;
      idle(4);
      done = 1'b1;
      report();
   end
endmodule